// File: doc/BRIEF.md
# Discharge-Path Protection Controller

This block decides whether the discharge switch of a two-cell battery pack may conduct. It also decides which way the load-side sense node is pulled. Every analog quantity reaches it as a digital comparator flag:
- an under-voltage flag for each cell;
- three flags on the load node, for at-or-above the over-current level, at-or-above the short-circuit level, and at-or-below the standby-release level;
- an over-charge-active flag from the charge-side controller.

Each detection and each release needs its condition to hold without a break for a set number of timebase ticks. The `tick` input is a one-cycle strobe from a shared prescaler. A test-mode pin shortens the counted delays, except the short-circuit delay.

There are three fault states: over-discharge, over-current and short-circuit. In all three the discharge switch is off.

Over-discharge normally puts the block into standby, with the load node pulled to the positive rail. Only a charger can end standby, by pulling the load node below the standby-release level. Over-current and short-circuit pull the load node to the negative rail and never enter standby.

The three faults are ranked against each other and against an active over-charge:
- over-charge masks over-current detection;
- over-charge defers standby;
- an over-discharge that arrives during an over-current takes over the pull and enters standby.

Top module: `dsg_guard`

## Requirements
- R1: In the normal state, if either bit of `cell_uv` is set for UV_DET_TICKS consecutive ticks, then on that edge `dsg_en` goes to 0 and `pull_sel` goes to 01. `standby` goes to 1 when `ovchg_active` was 0 at that edge.
- R2: While `standby` is 1, it stays 1 and no recovery of the cells releases the block. On the first edge where `load_le_stby` is 1, `standby` clears and cell monitoring resumes from the next edge.
- R3: In the over-discharge state with `standby` at 0, both cells clear for UV_REL_TICKS consecutive ticks set `dsg_en` to 1 and `pull_sel` to 00.
- R4: In the normal state, `load_ge_oc` held for OC_DET_TICKS consecutive ticks while `ovchg_active` is 0 sets `dsg_en` to 0 and `pull_sel` to 10, and leaves `standby` at 0.
- R5: In the normal state, `load_ge_sc` held for SC_DET_TICKS consecutive ticks enters the short-circuit state, with the same outputs as R4. Test mode does not shorten this count.
- R6: In the over-current or short-circuit state, `load_ge_oc` at 0 for LD_REL_TICKS consecutive ticks returns `dsg_en` to 1 and `pull_sel` to 00.
- R7: While `ovchg_active` is 1, `load_ge_oc` has no effect. Short-circuit detection (R5) still operates.
- R8: An over-discharge detected while `ovchg_active` is 1 leaves `standby` at 0. If `ovchg_active` then drops while either cell is still under-voltage, `standby` goes to 1 on the next edge.
- R9: Over-discharge detected during over-current changes `pull_sel` from 10 to 01 and sets `standby`. During over-discharge, `load_ge_oc` has no effect.
- R10: Encoding of `pull_sel`: 00 no pull, 01 pull to VDD, 10 pull to VSS. The code 11 never appears. Reset gives `dsg_en`=1, `standby`=0, `pull_sel`=00.
- R11: While `test_mode` is 1, the over-discharge and over-current detect and release counts are divided by TEST_DIV, with a minimum of 1.
- R12: A condition that drops before its count completes restarts its count from zero. Counts advance only on cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe; delay counts advance on it |
| test_mode | input | 1 | Shortens counted delays except short-circuit |
| cell_uv | input | 2 | Per-cell under-voltage flags |
| load_ge_oc | input | 1 | Load node at or above over-current level |
| load_ge_sc | input | 1 | Load node at or above short-circuit level |
| load_le_stby | input | 1 | Load node at or below standby-release level (charger present) |
| ovchg_active | input | 1 | Over-charge state active in the charge controller |
| dsg_en | output | 1 | Discharge switch enable |
| standby | output | 1 | Standby indication |
| pull_sel | output | 2 | Load-node pull selector (00 none, 01 VDD, 10 VSS) |

## Verification
With `tick` high on every cycle, a condition applied before edge 1 changes the outputs on edge N, where N is the count that applies. The bench therefore queues two expectations for each timed event: the unchanged outputs N-1 cycles after the stimulus, and the new outputs N cycles after it.

Leaving standby takes effect one edge after `load_le_stby` rises. The release count starts only on the edge after that, so the release expectation after a charger connection is placed at UV_REL_TICKS+1.

A monitor compares each queued expectation on the falling edge of the cycle it is due in, well clear of the registers' update.

// File: rtl/dsg_guard.sv
module dsg_guard #(
  parameter int UV_DET_TICKS = 800,
  parameter int UV_REL_TICKS = 8,
  parameter int OC_DET_TICKS = 160,
  parameter int LD_REL_TICKS = 8,
  parameter int SC_DET_TICKS = 2,
  parameter int TEST_DIV     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       test_mode,
  input  logic [1:0] cell_uv,
  input  logic       load_ge_oc,
  input  logic       load_ge_sc,
  input  logic       load_le_stby,
  input  logic       ovchg_active,
  output logic       dsg_en,
  output logic       standby,
  output logic [1:0] pull_sel
);

  localparam int UD_T = (UV_DET_TICKS / TEST_DIV > 0) ? UV_DET_TICKS / TEST_DIV : 1;
  localparam int UR_T = (UV_REL_TICKS / TEST_DIV > 0) ? UV_REL_TICKS / TEST_DIV : 1;
  localparam int OD_T = (OC_DET_TICKS / TEST_DIV > 0) ? OC_DET_TICKS / TEST_DIV : 1;
  localparam int LR_T = (LD_REL_TICKS / TEST_DIV > 0) ? LD_REL_TICKS / TEST_DIV : 1;
  localparam int UMAX = (UV_DET_TICKS > UV_REL_TICKS) ? UV_DET_TICKS : UV_REL_TICKS;
  localparam int OMAX = (OC_DET_TICKS > LD_REL_TICKS) ? OC_DET_TICKS : LD_REL_TICKS;
  localparam int UW   = $clog2(UMAX + 1);
  localparam int OW   = $clog2(OMAX + 1);
  localparam int SW   = $clog2(SC_DET_TICKS + 1);

  typedef enum logic [1:0] {S_RUN, S_OD, S_OC, S_SC} st_t;

  st_t st, st_nxt;
  logic od_def, def_nxt, stby_nxt;
  logic [UW-1:0] uv_cnt, uv_lim;
  logic [OW-1:0] oc_cnt, oc_lim;
  logic [SW-1:0] sc_cnt;
  logic uv_cond, oc_cond, sc_cond, uv_hit, oc_hit, sc_hit;

  wire in_od = (st == S_OD);
  wire in_ld = (st == S_OC) || (st == S_SC);

  assign uv_cond = in_od ? (!standby && cell_uv == 2'b00) : (|cell_uv);
  assign oc_cond = (st == S_RUN) ? (load_ge_oc && !ovchg_active) : (in_ld && !load_ge_oc);
  assign sc_cond = (st == S_RUN) && load_ge_sc;

  assign uv_lim = in_od ? (test_mode ? UW'(UR_T) : UW'(UV_REL_TICKS))
                        : (test_mode ? UW'(UD_T) : UW'(UV_DET_TICKS));
  assign oc_lim = in_ld ? (test_mode ? OW'(LR_T) : OW'(LD_REL_TICKS))
                        : (test_mode ? OW'(OD_T) : OW'(OC_DET_TICKS));

  assign uv_hit = tick && uv_cond && (uv_cnt >= uv_lim - 1'b1);
  assign oc_hit = tick && oc_cond && (oc_cnt >= oc_lim - 1'b1);
  assign sc_hit = tick && sc_cond && (sc_cnt >= SW'(SC_DET_TICKS - 1));

  always_comb begin
    st_nxt   = st;
    stby_nxt = standby;
    def_nxt  = od_def;
    case (st)
      S_OD: begin
        if (standby) begin
          if (load_le_stby) stby_nxt = 1'b0;
        end else if (od_def && !ovchg_active) begin
          def_nxt = 1'b0;
          if (|cell_uv) stby_nxt = 1'b1;
        end else if (uv_hit) begin
          st_nxt  = S_RUN;
          def_nxt = 1'b0;
        end
      end
      default: begin
        if (uv_hit) begin
          st_nxt   = S_OD;
          stby_nxt = !ovchg_active;
          def_nxt  = ovchg_active;
        end else if (st == S_RUN && sc_hit) begin
          st_nxt = S_SC;
        end else if (st == S_RUN && oc_hit) begin
          st_nxt = S_OC;
        end else if (in_ld && oc_hit) begin
          st_nxt = S_RUN;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_RUN;
      standby <= 1'b0;
      od_def  <= 1'b0;
      uv_cnt  <= '0;
      oc_cnt  <= '0;
      sc_cnt  <= '0;
    end else begin
      st      <= st_nxt;
      standby <= stby_nxt;
      od_def  <= def_nxt;

      if (!uv_cond || uv_hit)  uv_cnt <= '0;
      else if (tick)           uv_cnt <= uv_cnt + 1'b1;

      if (!oc_cond || oc_hit || st_nxt != st) oc_cnt <= '0;
      else if (tick)                          oc_cnt <= oc_cnt + 1'b1;

      if (!sc_cond || sc_hit || st_nxt != st) sc_cnt <= '0;
      else if (tick)                          sc_cnt <= sc_cnt + 1'b1;
    end
  end

  assign dsg_en   = (st == S_RUN);
  assign pull_sel = in_od ? 2'b01 : (in_ld ? 2'b10 : 2'b00);

endmodule

// File: rtl/dsg_guard_chk.sv
module dsg_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cell_uv,
  input logic       load_le_stby,
  input logic       ovchg_active,
  input logic       dsg_en,
  input logic       standby,
  input logic [1:0] pull_sel
);

  a_r10_pull_legal: assert property (@(posedge clk) disable iff (!rst_n)
    pull_sel != 2'b11);

  a_r1_standby_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (!dsg_en && pull_sel == 2'b01));

  a_r4_vss_pull_no_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_sel == 2'b10) |-> (!standby && !dsg_en));

  a_r2_standby_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !load_le_stby) |=> standby);

  a_r2_standby_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && load_le_stby) |=> !standby);

  a_r8_no_standby_in_overcharge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby) |-> !$past(ovchg_active));

  a_r3_release_needs_clear_cells: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dsg_en) && $past(pull_sel) == 2'b01) |-> ($past(cell_uv) == 2'b00));

endmodule

bind dsg_guard dsg_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cell_uv(cell_uv), .load_le_stby(load_le_stby),
  .ovchg_active(ovchg_active), .dsg_en(dsg_en), .standby(standby), .pull_sel(pull_sel)
);

// File: tb/sim_dsg_guard.sv
`timescale 1ns/1ps
module sim_dsg_guard;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, test_mode = 1'b0;
  logic [1:0] cell_uv = 2'b00;
  logic load_ge_oc = 1'b0, load_ge_sc = 1'b0, load_le_stby = 1'b0, ovchg_active = 1'b0;
  logic dsg_en, standby;
  logic [1:0] pull_sel;

  int cyc = 0, checks = 0, fails = 0;
  bit done = 1'b0;
  int q_due[$];
  logic [3:0] q_val[$];
  string q_tag[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dsg_guard u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .test_mode(test_mode),
    .cell_uv(cell_uv), .load_ge_oc(load_ge_oc), .load_ge_sc(load_ge_sc),
    .load_le_stby(load_le_stby), .ovchg_active(ovchg_active),
    .dsg_en(dsg_en), .standby(standby), .pull_sel(pull_sel));

  task automatic want(int d, logic dsg, logic sb, logic [1:0] pl, string tag);
    q_due.push_back(cyc + d);
    q_val.push_back({dsg, sb, pl});
    q_tag.push_back(tag);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    while (rst_n && q_due.size() > 0 && q_due[0] <= cyc) begin
      logic [3:0] e;
      string t;
      e = q_val.pop_front();
      t = q_tag.pop_front();
      void'(q_due.pop_front());
      checks++;
      if ({dsg_en, standby, pull_sel} !== e) begin
        fails++;
        $display("FAIL %s: dsg/stby/pull actual %b/%b/%b expected %b/%b/%b", t,
                 dsg_en, standby, pull_sel, e[3], e[2], e[1:0]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    want(1, 1, 0, 2'b00, "R10 reset state");
    step(2);

    // R12 interrupted count, then R4 over-current
    load_ge_oc = 1; step(40); load_ge_oc = 0; step(1); load_ge_oc = 1;
    want(159, 1, 0, 2'b00, "R12 restart after gap");
    want(160, 0, 0, 2'b10, "R4 over-current detect");
    step(160);
    load_ge_oc = 0;
    want(7, 0, 0, 2'b10, "R6 release not yet");
    want(8, 1, 0, 2'b00, "R6 over-current release");
    step(8);

    // R7 over-charge masks over-current, not short-circuit
    ovchg_active = 1; load_ge_oc = 1;
    want(200, 1, 0, 2'b00, "R7 over-current masked");
    step(200);
    load_ge_sc = 1;
    want(1, 1, 0, 2'b00, "R7 short-circuit counting");
    want(2, 0, 0, 2'b10, "R7 short-circuit still detected");
    step(2);
    load_ge_sc = 0; load_ge_oc = 0; ovchg_active = 0;
    want(7, 0, 0, 2'b10, "R6 short release not yet");
    want(8, 1, 0, 2'b00, "R6 short-circuit release");
    step(8);

    // R5 short count not shortened, R11 release shortened
    test_mode = 1; load_ge_sc = 1; load_ge_oc = 1;
    want(1, 1, 0, 2'b00, "R5 short count unchanged in test mode");
    want(2, 0, 0, 2'b10, "R5 short-circuit detect");
    step(2);
    load_ge_sc = 0; load_ge_oc = 0;
    want(1, 1, 0, 2'b00, "R11 release shortened");
    step(1);
    load_ge_oc = 1;
    want(19, 1, 0, 2'b00, "R11 over-current not yet");
    want(20, 0, 0, 2'b10, "R11 over-current shortened");
    step(20);
    load_ge_oc = 0;
    want(1, 1, 0, 2'b00, "R11 release");
    step(1);
    test_mode = 0;

    // R1 over-discharge, R2 standby hold and exit, R3 release
    cell_uv = 2'b01;
    want(799, 1, 0, 2'b00, "R1 not yet");
    want(800, 0, 1, 2'b01, "R1 over-discharge with standby");
    step(800);
    cell_uv = 2'b00;
    want(20, 0, 1, 2'b01, "R2 standby held with cells clear");
    step(20);
    cell_uv = 2'b01; load_le_stby = 1;
    want(1, 0, 0, 2'b01, "R2 charger ends standby");
    step(1);
    load_le_stby = 0;
    want(10, 0, 0, 2'b01, "R2 monitoring, cell still low");
    step(10);
    cell_uv = 2'b00;
    want(7, 0, 0, 2'b01, "R3 not yet");
    want(8, 1, 0, 2'b00, "R3 over-discharge release");
    step(8);

    // R8 over-discharge during over-charge
    ovchg_active = 1; cell_uv = 2'b10;
    want(800, 0, 0, 2'b01, "R8 no standby during over-charge");
    step(800);
    ovchg_active = 0;
    want(1, 0, 1, 2'b01, "R8 standby after over-charge ends");
    step(1);
    load_le_stby = 1; cell_uv = 2'b00;
    want(1, 0, 0, 2'b01, "R2 exit");
    want(8, 0, 0, 2'b01, "R3 release not yet after exit");
    want(9, 1, 0, 2'b00, "R3 release after charger");
    step(9);
    load_le_stby = 0;

    // R9 over-current first, then over-discharge
    cell_uv = 2'b01; load_ge_oc = 1;
    want(160, 0, 0, 2'b10, "R9 over-current first");
    want(800, 0, 1, 2'b01, "R9 over-discharge takes pull");
    step(800);
    load_ge_oc = 0; load_le_stby = 1;
    want(1, 0, 0, 2'b01, "R2 exit");
    step(1);
    load_le_stby = 0; load_ge_oc = 1;
    want(200, 0, 0, 2'b01, "R9 over-current suspended");
    step(200);
    cell_uv = 2'b00;
    want(8, 1, 0, 2'b00, "R3 release");
    want(168, 0, 0, 2'b10, "R4 over-current after release");
    step(168);
    load_ge_oc = 0;
    want(8, 1, 0, 2'b00, "R6 release");
    step(10);

    while (q_due.size() > 0) step(1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule